// File: doc/BRIEF.md
# Edge-Selectable Input Capture Channel

This block is a single timestamp channel for a timer subsystem. It watches one asynchronous input pin. When the chosen transition appears on that pin, it copies the running 16-bit timer count into a capture register and raises a channel flag. The flag can drive an interrupt request when the channel's interrupt enable is set.

Software picks which transitions count through a 2-bit edge selector: none, rising, falling, or both. It clears the flag either by writing a one to the flag bit or, when fast clearing is enabled, by reading the captured value. While the channel is configured for output compare, it takes no timestamps. The pin passes through a two-stage synchronizer before edge detection, so each event is timestamped a fixed number of cycles after it reaches the pin.

Top module: `edge_capture_channel`

## Requirements
- R1: After reset the capture value is 0, the flag is 0 and the interrupt request is 0.
- R2: With edge_sel = 2'b00 no transition of the pin sets the flag or changes the capture value.
- R3: With edge_sel = 2'b01 a 0-to-1 pin transition captures and sets the flag; a 1-to-0 transition does neither.
- R4: With edge_sel = 2'b10 a 1-to-0 pin transition captures and sets the flag; a 0-to-1 transition does neither.
- R5: With edge_sel = 2'b11 both pin transitions capture and set the flag.
- R6: A pin change driven just after a falling clock edge is detected after two synchronizer stages. The value stored is count_in as sampled on the third rising clock edge after that change, and the flag and capture value appear on the outputs after that edge. The flag never sets without a capture.
- R7: A strobe on flag_wr with flag_wr_bit = 1 clears the flag; with flag_wr_bit = 0 the flag is unchanged.
- R8: A strobe on rd_strobe clears the flag when fast_clr_en = 1 and leaves it unchanged when fast_clr_en = 0.
- R9: irq is 1 exactly while the flag is 1 and irq_en is 1.
- R10: While mode_compare = 1, pin transitions neither capture nor set the flag.
- R11: A selected edge that arrives while the flag is already set overwrites the capture value, and the flag stays set.
- R12: When a capture and a clear (write or fast-clear read) fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Asynchronous event pin |
| count_in | input | 16 | Running timer count |
| edge_sel | input | 2 | Edge selector: 00 off, 01 rising, 10 falling, 11 both |
| mode_compare | input | 1 | 1 when the channel is used as output compare (capture blocked) |
| irq_en | input | 1 | Channel interrupt enable |
| fast_clr_en | input | 1 | Enables flag clearing on a capture read |
| rd_strobe | input | 1 | One-cycle pulse marking a read of the capture value |
| flag_wr | input | 1 | One-cycle pulse marking a write to the flag register |
| flag_wr_bit | input | 1 | Data bit written with flag_wr (1 clears) |
| cap_value | output | 16 | Captured timer count |
| flag | output | 1 | Channel event flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a capture that lands in the same cycle as a clear, because the detection cycle lies two synchronizer stages after the pin change. The stimulus counts clock edges from the pin change and pulses the write or read strobe in exactly the detection cycle. The same counting drives a timer count that advances every cycle, so an off-by-one in the synchronizer depth shows up as a wrong captured value.

// File: rtl/edge_capture_pkg.sv
`timescale 1ns/1ps
package edge_capture_pkg;

    typedef enum logic [1:0] {
        SEL_OFF  = 2'b00,
        SEL_RISE = 2'b01,
        SEL_FALL = 2'b10,
        SEL_BOTH = 2'b11
    } edge_sel_e;

endpackage

// File: rtl/edge_capture_sync.sv
`timescale 1ns/1ps
module edge_capture_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.chain[TOP];
endmodule

// File: rtl/edge_capture_detect.sv
`timescale 1ns/1ps
module edge_capture_detect
    import edge_capture_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_in,
    input  logic [1:0] sel,
    input  logic       allow,
    output logic       hit
);
    typedef struct packed {
        logic prev;
    } det_state_t;

    det_state_t st_d, st_q;
    logic       went_up, went_down;
    edge_sel_e  mode;

    always_comb begin
        mode      = edge_sel_e'(sel);
        st_d.prev = level_in;
        went_up   = level_in & ~st_q.prev;
        went_down = ~level_in & st_q.prev;
        unique case (mode)
            SEL_RISE: hit = allow & went_up;
            SEL_FALL: hit = allow & went_down;
            SEL_BOTH: hit = allow & (went_up | went_down);
            default:  hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/edge_capture_store.sv
`timescale 1ns/1ps
module edge_capture_store #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [CNT_W-1:0] count_in,
    input  logic             clr,
    output logic [CNT_W-1:0] value,
    output logic             flag
);
    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic             flag;
    } store_state_t;

    store_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)  st_d.flag = 1'b0;
        if (fire) begin
            st_d.value = count_in;
            st_d.flag  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.value;
    assign flag  = st_q.flag;
endmodule

// File: rtl/edge_capture_channel.sv
`timescale 1ns/1ps
module edge_capture_channel #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic [CNT_W-1:0] count_in,
    input  logic [1:0]       edge_sel,
    input  logic             mode_compare,
    input  logic             irq_en,
    input  logic             fast_clr_en,
    input  logic             rd_strobe,
    input  logic             flag_wr,
    input  logic             flag_wr_bit,
    output logic [CNT_W-1:0] cap_value,
    output logic             flag,
    output logic             irq
);
    logic pin_sync;
    logic cap_fire;
    logic clr_req;

    edge_capture_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    edge_capture_detect u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (pin_sync),
        .sel      (edge_sel),
        .allow    (~mode_compare),
        .hit      (cap_fire)
    );

    always_comb begin
        clr_req = (flag_wr & flag_wr_bit) | (rd_strobe & fast_clr_en);
    end

    edge_capture_store #(.CNT_W(CNT_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (cap_fire),
        .count_in (count_in),
        .clr      (clr_req),
        .value    (cap_value),
        .flag     (flag)
    );

    assign irq = flag & irq_en;
endmodule

// File: rtl/edge_capture_chk.sv
`timescale 1ns/1ps
module edge_capture_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_fire,
    input logic [1:0]       edge_sel,
    input logic             mode_compare,
    input logic             fast_clr_en,
    input logic             rd_strobe,
    input logic             flag_wr,
    input logic             flag_wr_bit,
    input logic [CNT_W-1:0] cap_value,
    input logic             flag
);
    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel == 2'b00) |=> $stable(cap_value)); // R2
    AST_CMP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_compare |=> $stable(cap_value)); // R10
    AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !cap_fire) |=> !flag); // R6
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && flag_wr && flag_wr_bit && !cap_fire) |=> !flag); // R7
    AST_FAST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && rd_strobe && fast_clr_en && !cap_fire) |=> !flag); // R8
    AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && rd_strobe && !fast_clr_en && !(flag_wr && flag_wr_bit)) |=> flag); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> flag); // R12
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_fire |=> $stable(cap_value)); // R11
endmodule

bind edge_capture_channel edge_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap_fire     (cap_fire),
    .edge_sel     (edge_sel),
    .mode_compare (mode_compare),
    .fast_clr_en  (fast_clr_en),
    .rd_strobe    (rd_strobe),
    .flag_wr      (flag_wr),
    .flag_wr_bit  (flag_wr_bit),
    .cap_value    (cap_value),
    .flag         (flag)
);

// File: tb/tb_edge_capture_channel.sv
`timescale 1ns/1ps
module tb_edge_capture_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic [15:0] count_in = 16'h1000;
    logic [1:0]  edge_sel = 2'b00;
    logic        mode_compare = 1'b0;
    logic        irq_en = 1'b0;
    logic        fast_clr_en = 1'b0;
    logic        rd_strobe = 1'b0;
    logic        flag_wr = 1'b0;
    logic        flag_wr_bit = 1'b0;
    logic [15:0] cap_value;
    logic        flag;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    initial forever begin
        @(negedge clk);
        count_in = count_in + 16'd1;
    end

    edge_capture_channel dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .count_in(count_in),
        .edge_sel(edge_sel), .mode_compare(mode_compare), .irq_en(irq_en),
        .fast_clr_en(fast_clr_en), .rd_strobe(rd_strobe), .flag_wr(flag_wr),
        .flag_wr_bit(flag_wr_bit), .cap_value(cap_value), .flag(flag), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive pin to v; optionally pulse write-1 or read strobe in the detection cycle.
    // Returns the count value the design samples on the third rising edge.
    task automatic drive_pin(input logic v, input logic wr1, input logic rd, output logic [15:0] exp_cnt);
        @(negedge clk);
        pin_in = v;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        #1;
        exp_cnt = count_in;
        if (wr1) begin flag_wr = 1'b1; flag_wr_bit = 1'b1; end
        if (rd)  rd_strobe = 1'b1;
        @(negedge clk);
        flag_wr = 1'b0; flag_wr_bit = 1'b0; rd_strobe = 1'b0;
        #1;
    endtask

    task automatic write_flag(input logic b);
        @(negedge clk);
        flag_wr = 1'b1; flag_wr_bit = b;
        @(negedge clk);
        flag_wr = 1'b0; flag_wr_bit = 1'b0;
        #1;
    endtask

    task automatic read_cap();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        check("R1 cap", cap_value, 16'h0000);
        check("R1 flag", {15'd0, flag}, 16'd0);
        check("R1 irq", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_off();
        logic [15:0] e;
        edge_sel = 2'b00;
        drive_pin(1'b1, 1'b0, 1'b0, e);
        drive_pin(1'b0, 1'b0, 1'b0, e);
        check("R2 flag", {15'd0, flag}, 16'd0);
        check("R2 cap", cap_value, 16'h0000);
    endtask

    task automatic t_rise();
        logic [15:0] e, held;
        edge_sel = 2'b01;
        drive_pin(1'b1, 1'b0, 1'b0, e);
        check("R3 flag on rise", {15'd0, flag}, 16'd1);
        check("R6 cap value", cap_value, e);
        held = cap_value;
        write_flag(1'b0);
        check("R7 write0 keeps", {15'd0, flag}, 16'd1);
        write_flag(1'b1);
        check("R7 write1 clears", {15'd0, flag}, 16'd0);
        drive_pin(1'b0, 1'b0, 1'b0, e);
        check("R3 no flag on fall", {15'd0, flag}, 16'd0);
        check("R3 cap held on fall", cap_value, held);
    endtask

    task automatic t_fall();
        logic [15:0] e, held;
        edge_sel = 2'b10;
        held = cap_value;
        drive_pin(1'b1, 1'b0, 1'b0, e);
        check("R4 no flag on rise", {15'd0, flag}, 16'd0);
        check("R4 cap held on rise", cap_value, held);
        drive_pin(1'b0, 1'b0, 1'b0, e);
        check("R4 flag on fall", {15'd0, flag}, 16'd1);
        check("R4 cap on fall", cap_value, e);
        write_flag(1'b1);
    endtask

    task automatic t_both();
        logic [15:0] e;
        edge_sel = 2'b11;
        drive_pin(1'b1, 1'b0, 1'b0, e);
        check("R5 rise flag", {15'd0, flag}, 16'd1);
        check("R5 rise cap", cap_value, e);
        write_flag(1'b1);
        drive_pin(1'b0, 1'b0, 1'b0, e);
        check("R5 fall flag", {15'd0, flag}, 16'd1);
        check("R5 fall cap", cap_value, e);
    endtask

    task automatic t_irq();
        // flag is set on entry
        irq_en = 1'b1; #1;
        check("R9 irq on", {15'd0, irq}, 16'd1);
        irq_en = 1'b0; #1;
        check("R9 irq gated", {15'd0, irq}, 16'd0);
        irq_en = 1'b1;
        write_flag(1'b1);
        check("R9 irq follows flag", {15'd0, irq}, 16'd0);
        irq_en = 1'b0;
    endtask

    task automatic t_fast();
        logic [15:0] e;
        edge_sel = 2'b11;
        drive_pin(1'b1, 1'b0, 1'b0, e);
        fast_clr_en = 1'b0;
        read_cap();
        check("R8 read keeps flag", {15'd0, flag}, 16'd1);
        fast_clr_en = 1'b1;
        read_cap();
        check("R8 fast read clears", {15'd0, flag}, 16'd0);
    endtask

    task automatic t_compare();
        logic [15:0] e, held;
        edge_sel = 2'b11;
        mode_compare = 1'b1;
        held = cap_value;
        drive_pin(1'b0, 1'b0, 1'b0, e);
        check("R10 no flag", {15'd0, flag}, 16'd0);
        check("R10 cap held", cap_value, held);
        mode_compare = 1'b0;
    endtask

    task automatic t_overwrite();
        logic [15:0] e1, e2;
        edge_sel = 2'b11;
        drive_pin(1'b1, 1'b0, 1'b0, e1);
        drive_pin(1'b0, 1'b0, 1'b0, e2);
        check("R11 flag stays", {15'd0, flag}, 16'd1);
        check("R11 cap overwritten", cap_value, e2);
        write_flag(1'b1);
    endtask

    task automatic t_collide();
        logic [15:0] e;
        edge_sel = 2'b11;
        drive_pin(1'b1, 1'b1, 1'b0, e);
        check("R12 set beats write", {15'd0, flag}, 16'd1);
        check("R12 cap on write collision", cap_value, e);
        write_flag(1'b1);
        fast_clr_en = 1'b1;
        drive_pin(1'b0, 1'b0, 1'b1, e);
        check("R12 set beats fast read", {15'd0, flag}, 16'd1);
        fast_clr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_off();
        t_rise();
        t_fall();
        t_both();
        t_irq();
        t_fast();
        t_compare();
        t_overwrite();
        t_collide();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule